// File: doc/BRIEF.md
# Display Bridge Bring-Up Sequencer

This block walks a parallel-RGB-to-DSI bridge from power-on to streaming video. It drives the bridge's active-low reset line and issues a fixed series of register reads and writes through an external register-access port. The port is modelled as a request stream (valid/ready) plus a completion pulse that carries read data. After a `start` pulse, the sequencer performs these steps in order:

1. It holds the bridge in reset, then releases it and lets it settle.
2. It optionally confirms the bridge's identity and the power-on value of its configuration register.
3. It loads the video timing, lane and configuration registers.
4. It programs and enables the PLL, then waits for lock.
5. It sends the two panel wake-up commands, each followed by its own delay.
6. It switches the data lanes to high speed and enables video.

The timing values, the PLL word and the low-power clock divider are supplied as inputs. They must stay stable while `busy` is high. The outcome is reported on `done` or `error`, and either flag stays set until the next `start`. Millisecond and microsecond delays are derived from the clock through parameters `CLK_MHZ` (cycles per microsecond) and `US_PER_MS`.

The request stream follows these back-pressure rules:
- While `acc_valid` is high and `acc_ready` is low, the request (`acc_write`, `acc_addr`, `acc_wdata`) holds unchanged.
- A request is accepted in the cycle where both `acc_valid` and `acc_ready` are high.
- After acceptance, no new request is raised until `acc_done` is seen.
- `acc_done` must arrive in a cycle after the acceptance cycle, not in it.
- For reads, `acc_rdata` is sampled in the `acc_done` cycle.

Top module: `bridge_init_seq`

## Requirements
- R1: After `rst_n` is released, `bridge_rst_n`=1 and `acc_valid`, `busy`, `done` and `error` are all 0.
- R2: On `start`, `bridge_rst_n` goes low for RST_MS (10) milliseconds and then high. No request is raised while it is low or within 10 ms after it rises.
- R3: When `readback_en`=1, the first two requests are reads (`acc_write`=0) of address 0xB0 and then 0xB7. If the first returns other than 0x2828, or the second other than 0x0301, the sequence ends with `error`=1 and `busy`=0. No further request follows and `bridge_rst_n` stays high.
- R4: When `readback_en`=0, no read is issued, and the first request is the write to 0xB1.
- R5: Timing writes go out in this order:
  - 0xB1 = {vsync_len, hsync_len}
  - 0xB2 = {vsync_len+vbp_len, hsync_len+hbp_len}, each byte summed modulo 256
  - 0xB3 = {vfp_len, hfp_len}
  - 0xB4 = h_active
  - 0xB5 = v_active
  - 0xB6 = 0x0008 | pix_fmt (burst mode)
  - 0xDE = lane_cnt−1
- R6: The next write sets 0xB7 to 0x0342, or to 0x0362 when `pclk_ref`=1. Bit 0 (data-lane HS) is clear; bit 1 (clock-lane HS) and bit 6 (command-only packets) are set; bit 5 marks the pixel clock as PLL reference.
- R7: The PLL steps then write 0xBA = pll_word, 0xB8 = 0, 0xBB = lp_div zero-extended, and 0xB9 = 1. At least 500 µs pass between completion of the 0xB9 write and the next request.
- R8: Panel commands are sent as 0xBC = 1, 0xBF = 0x0011, a wait of sleep_exit_ms milliseconds, then 0xBC = 1, 0xBF = 0x0029, and a wait of disp_on_ms milliseconds. A zero wait adds no delay.
- R9: The last write sets 0xB7 to the R6 value with bit 0 and bit 3 also set (0x034B, or 0x036B with `pclk_ref`). Then `done`=1 and `busy`=0, and `done` holds until the next `start`.
- R10: Each request holds stable while not accepted. There is only one outstanding request at a time. `acc_valid` is 0 whenever `busy` is 0.
- R11: A `start` pulse while `busy`=1 has no effect: the reset line is not pulsed again and the request series continues unchanged.
- R12: A `start` after `done` or `error` clears both flags and runs the whole sequence again from the reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| start | input | 1 | Begin the bring-up sequence (ignored while busy) |
| readback_en | input | 1 | Perform identity / default readback check |
| pclk_ref | input | 1 | Pixel clock is the PLL reference |
| hsync_len | input | 8 | Horizontal sync width |
| hbp_len | input | 8 | Horizontal back margin |
| hfp_len | input | 8 | Horizontal front margin |
| vsync_len | input | 8 | Vertical sync width |
| vbp_len | input | 8 | Vertical back margin |
| vfp_len | input | 8 | Vertical front margin |
| h_active | input | 16 | Active pixels per line |
| v_active | input | 16 | Active lines per frame |
| pix_fmt | input | 2 | Pixel format code |
| lane_cnt | input | 3 | Number of data lanes (1..4) |
| pll_word | input | 16 | PLL configuration word |
| lp_div | input | 6 | Low-power clock divider field |
| sleep_exit_ms | input | 16 | Delay after the wake command, ms |
| disp_on_ms | input | 16 | Delay after the display-on command, ms |
| bridge_rst_n | output | 1 | Active-low reset to the bridge |
| acc_valid | output | 1 | Register request valid |
| acc_ready | input | 1 | Register port accepts request |
| acc_write | output | 1 | 1 = write, 0 = read |
| acc_addr | output | 8 | Register address |
| acc_wdata | output | 16 | Write data |
| acc_done | input | 1 | Completion pulse of the accepted request |
| acc_rdata | input | 16 | Read data, valid with acc_done |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished successfully (sticky) |
| error | output | 1 | Readback check failed (sticky) |

## Verification
Two events can fall on consecutive edges with nothing in between. The first is the port's acceptance of a request. The second is that request's completion pulse, which is then immediately followed by the sequencer's next request. A responder with zero ready and zero completion latency provokes this, and a run with ready and done delays serves as contrast. In both runs, every request is compared in order against an expected list built from the requirements, and the gaps across the reset, lock and panel waits are measured in cycles. A `start` pulse also lands during an active sequence; it is judged correct by the absence of any second reset pulse or extra request.

// File: rtl/bridge_seq_pkg.sv
package bridge_seq_pkg;

  typedef enum logic [2:0] {
    K_RST_LO,
    K_RST_HI,
    K_READ,
    K_WRITE,
    K_WAIT_US,
    K_WAIT_MS,
    K_END
  } step_kind_e;

  typedef struct packed {
    step_kind_e  kind;
    logic [7:0]  addr;
    logic [15:0] data;   // write data, or expected read value
    logic [15:0] dly;    // delay count for reset and wait steps
  } step_t;

  localparam int unsigned NUM_STEPS = 25;
  localparam int unsigned IDXW      = $clog2(NUM_STEPS + 1);

  localparam logic [7:0] RA_ID      = 8'hB0;
  localparam logic [7:0] RA_SYNC    = 8'hB1;
  localparam logic [7:0] RA_BACK    = 8'hB2;
  localparam logic [7:0] RA_FRONT   = 8'hB3;
  localparam logic [7:0] RA_HACT    = 8'hB4;
  localparam logic [7:0] RA_VACT    = 8'hB5;
  localparam logic [7:0] RA_VMODE   = 8'hB6;
  localparam logic [7:0] RA_CFG     = 8'hB7;
  localparam logic [7:0] RA_VCHAN   = 8'hB8;
  localparam logic [7:0] RA_PLLEN   = 8'hB9;
  localparam logic [7:0] RA_PLLW    = 8'hBA;
  localparam logic [7:0] RA_LPDIV   = 8'hBB;
  localparam logic [7:0] RA_PKTSZ   = 8'hBC;
  localparam logic [7:0] RA_PAYLD   = 8'hBF;
  localparam logic [7:0] RA_LANES   = 8'hDE;

  localparam logic [15:0] ID_VALUE    = 16'h2828;
  localparam logic [15:0] CFG_DEFAULT = 16'h0301;
  localparam logic [15:0] CFG_BASE    = 16'h0342;
  localparam logic [15:0] CFG_PCLK    = 16'h0020;
  localparam logic [15:0] CFG_STREAM  = 16'h0009;
  localparam logic [15:0] VMODE_BURST = 16'h0008;
  localparam logic [15:0] CMD_WAKE    = 16'h0011;
  localparam logic [15:0] CMD_DISP_ON = 16'h0029;

endpackage

// File: rtl/bridge_delay_timer.sv
module bridge_delay_timer #(
  parameter int unsigned CLK_MHZ   = 50,
  parameter int unsigned US_PER_MS = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        ms_unit,
  input  logic [15:0] count,
  output logic        expired
);
  localparam int unsigned USW = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;
  localparam int unsigned MSW = (US_PER_MS > 1) ? $clog2(US_PER_MS) : 1;

  logic [USW-1:0] pre_us;
  logic [MSW-1:0] pre_ms;
  logic [15:0]    remain;
  logic           armed;
  logic           unit_ms;
  logic           us_tick, ms_tick, step_tick;

  assign us_tick   = (pre_us == USW'(CLK_MHZ - 1));
  assign ms_tick   = us_tick && (pre_ms == MSW'(US_PER_MS - 1));
  assign step_tick = unit_ms ? ms_tick : us_tick;
  assign expired   = armed && (remain == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_us  <= '0;
      pre_ms  <= '0;
      remain  <= '0;
      armed   <= 1'b0;
      unit_ms <= 1'b0;
    end else if (load) begin
      pre_us  <= '0;
      pre_ms  <= '0;
      remain  <= count;
      armed   <= 1'b1;
      unit_ms <= ms_unit;
    end else if (armed && remain != '0) begin
      pre_us <= us_tick ? '0 : pre_us + 1'b1;
      if (us_tick) pre_ms <= ms_tick ? '0 : pre_ms + 1'b1;
      if (step_tick) remain <= remain - 1'b1;
    end
  end

  AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !load) |=> (remain == $past(remain) || remain == $past(remain) - 16'd1)); // R7
  AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired); // R8
endmodule

// File: rtl/bridge_step_table.sv
module bridge_step_table
  import bridge_seq_pkg::*;
#(
  parameter int unsigned RST_MS  = 10,
  parameter int unsigned LOCK_US = 500
) (
  input  logic [IDXW-1:0] idx,
  input  logic            pclk_ref,
  input  logic [7:0]      hsync_len,
  input  logic [7:0]      hbp_len,
  input  logic [7:0]      hfp_len,
  input  logic [7:0]      vsync_len,
  input  logic [7:0]      vbp_len,
  input  logic [7:0]      vfp_len,
  input  logic [15:0]     h_active,
  input  logic [15:0]     v_active,
  input  logic [1:0]      pix_fmt,
  input  logic [2:0]      lane_cnt,
  input  logic [15:0]     pll_word,
  input  logic [5:0]      lp_div,
  input  logic [15:0]     sleep_exit_ms,
  input  logic [15:0]     disp_on_ms,
  output step_t           step
);
  logic [15:0] cfg_run;
  logic [7:0]  vback, hback;
  logic [2:0]  lanes_m1;

  assign cfg_run  = CFG_BASE | (pclk_ref ? CFG_PCLK : 16'h0000);
  assign vback    = vsync_len + vbp_len;
  assign hback    = hsync_len + hbp_len;
  assign lanes_m1 = lane_cnt - 3'd1;

  function automatic step_t wr(input logic [7:0] a, input logic [15:0] d);
    return '{kind: K_WRITE, addr: a, data: d, dly: 16'd0};
  endfunction

  always_comb begin
    unique case (idx)
      5'd0:  step = '{kind: K_RST_LO, addr: 8'h00, data: 16'h0, dly: 16'(RST_MS)};
      5'd1:  step = '{kind: K_RST_HI, addr: 8'h00, data: 16'h0, dly: 16'(RST_MS)};
      5'd2:  step = '{kind: K_READ, addr: RA_ID,  data: ID_VALUE,    dly: 16'd0};
      5'd3:  step = '{kind: K_READ, addr: RA_CFG, data: CFG_DEFAULT, dly: 16'd0};
      5'd4:  step = wr(RA_SYNC,  {vsync_len, hsync_len});
      5'd5:  step = wr(RA_BACK,  {vback, hback});
      5'd6:  step = wr(RA_FRONT, {vfp_len, hfp_len});
      5'd7:  step = wr(RA_HACT,  h_active);
      5'd8:  step = wr(RA_VACT,  v_active);
      5'd9:  step = wr(RA_VMODE, VMODE_BURST | {14'd0, pix_fmt});
      5'd10: step = wr(RA_LANES, {13'd0, lanes_m1});
      5'd11: step = wr(RA_CFG,   cfg_run);
      5'd12: step = wr(RA_PLLW,  pll_word);
      5'd13: step = wr(RA_VCHAN, 16'h0000);
      5'd14: step = wr(RA_LPDIV, {10'd0, lp_div});
      5'd15: step = wr(RA_PLLEN, 16'h0001);
      5'd16: step = '{kind: K_WAIT_US, addr: 8'h00, data: 16'h0, dly: 16'(LOCK_US)};
      5'd17: step = wr(RA_PKTSZ, 16'h0001);
      5'd18: step = wr(RA_PAYLD, CMD_WAKE);
      5'd19: step = '{kind: K_WAIT_MS, addr: 8'h00, data: 16'h0, dly: sleep_exit_ms};
      5'd20: step = wr(RA_PKTSZ, 16'h0001);
      5'd21: step = wr(RA_PAYLD, CMD_DISP_ON);
      5'd22: step = '{kind: K_WAIT_MS, addr: 8'h00, data: 16'h0, dly: disp_on_ms};
      5'd23: step = wr(RA_CFG, cfg_run | CFG_STREAM);
      default: step = '{kind: K_END, addr: 8'h00, data: 16'h0, dly: 16'd0};
    endcase
  end
endmodule

// File: rtl/bridge_init_seq.sv
module bridge_init_seq
  import bridge_seq_pkg::*;
#(
  parameter int unsigned CLK_MHZ   = 50,
  parameter int unsigned US_PER_MS = 1000,
  parameter int unsigned RST_MS    = 10,
  parameter int unsigned LOCK_US   = 500
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        readback_en,
  input  logic        pclk_ref,
  input  logic [7:0]  hsync_len,
  input  logic [7:0]  hbp_len,
  input  logic [7:0]  hfp_len,
  input  logic [7:0]  vsync_len,
  input  logic [7:0]  vbp_len,
  input  logic [7:0]  vfp_len,
  input  logic [15:0] h_active,
  input  logic [15:0] v_active,
  input  logic [1:0]  pix_fmt,
  input  logic [2:0]  lane_cnt,
  input  logic [15:0] pll_word,
  input  logic [5:0]  lp_div,
  input  logic [15:0] sleep_exit_ms,
  input  logic [15:0] disp_on_ms,
  output logic        bridge_rst_n,
  output logic        acc_valid,
  input  logic        acc_ready,
  output logic        acc_write,
  output logic [7:0]  acc_addr,
  output logic [15:0] acc_wdata,
  input  logic        acc_done,
  input  logic [15:0] acc_rdata,
  output logic        busy,
  output logic        done,
  output logic        error
);
  typedef enum logic [2:0] {S_IDLE, S_EXEC, S_ISSUE, S_WAIT, S_DELAY, S_DONE, S_ERR} state_e;

  state_e          state;
  logic [IDXW-1:0] idx;
  step_t           step;
  logic [15:0]     req_exp;
  logic            tmr_load, tmr_expired;

  bridge_step_table #(.RST_MS(RST_MS), .LOCK_US(LOCK_US)) u_table (
    .idx(idx), .pclk_ref(pclk_ref),
    .hsync_len(hsync_len), .hbp_len(hbp_len), .hfp_len(hfp_len),
    .vsync_len(vsync_len), .vbp_len(vbp_len), .vfp_len(vfp_len),
    .h_active(h_active), .v_active(v_active), .pix_fmt(pix_fmt),
    .lane_cnt(lane_cnt), .pll_word(pll_word), .lp_div(lp_div),
    .sleep_exit_ms(sleep_exit_ms), .disp_on_ms(disp_on_ms),
    .step(step)
  );

  always_comb begin
    tmr_load = 1'b0;
    if (state == S_EXEC) begin
      unique case (step.kind)
        K_RST_LO, K_RST_HI:   tmr_load = 1'b1;
        K_WAIT_US, K_WAIT_MS: tmr_load = (step.dly != '0);
        default:              tmr_load = 1'b0;
      endcase
    end
  end

  bridge_delay_timer #(.CLK_MHZ(CLK_MHZ), .US_PER_MS(US_PER_MS)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load),
    .ms_unit(step.kind != K_WAIT_US), .count(step.dly),
    .expired(tmr_expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      idx          <= '0;
      bridge_rst_n <= 1'b1;
      acc_write    <= 1'b0;
      acc_addr     <= '0;
      acc_wdata    <= '0;
      req_exp      <= '0;
      done         <= 1'b0;
      error        <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE, S_DONE, S_ERR: if (start) begin
          idx   <= '0;
          done  <= 1'b0;
          error <= 1'b0;
          state <= S_EXEC;
        end
        S_EXEC: begin
          unique case (step.kind)
            K_RST_LO: begin bridge_rst_n <= 1'b0; state <= S_DELAY; end
            K_RST_HI: begin bridge_rst_n <= 1'b1; state <= S_DELAY; end
            K_READ: if (readback_en) begin
              acc_write <= 1'b0;
              acc_addr  <= step.addr;
              acc_wdata <= '0;
              req_exp   <= step.data;
              state     <= S_ISSUE;
            end else idx <= idx + 1'b1;
            K_WRITE: begin
              acc_write <= 1'b1;
              acc_addr  <= step.addr;
              acc_wdata <= step.data;
              state     <= S_ISSUE;
            end
            K_WAIT_US, K_WAIT_MS: if (step.dly == '0) idx <= idx + 1'b1;
                                  else state <= S_DELAY;
            default: begin done <= 1'b1; state <= S_DONE; end
          endcase
        end
        S_ISSUE: if (acc_ready) state <= S_WAIT;
        S_WAIT: if (acc_done) begin
          if (!acc_write && acc_rdata != req_exp) begin
            error <= 1'b1;
            state <= S_ERR;
          end else begin
            idx   <= idx + 1'b1;
            state <= S_EXEC;
          end
        end
        S_DELAY: if (tmr_expired) begin
          idx   <= idx + 1'b1;
          state <= S_EXEC;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign acc_valid = (state == S_ISSUE);
  assign busy      = (state != S_IDLE) && (state != S_DONE) && (state != S_ERR);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_ready) |=> (acc_valid && $stable(acc_addr) && $stable(acc_wdata) && $stable(acc_write))); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !acc_valid); // R10
  AST_RST_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !bridge_rst_n |-> !acc_valid); // R2
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error)); // R3
  AST_ERR_RST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> bridge_rst_n); // R3
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R9
  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bridge_rst_n && !acc_valid && $past(bridge_rst_n) && start) |=> bridge_rst_n); // R11
endmodule

// File: tb/tb_bridge_init_seq.sv
module tb_bridge_init_seq;
  localparam int CLK_MHZ = 2;
  localparam int UPM     = 20;
  localparam int TMS     = CLK_MHZ * UPM;
  localparam int T_RST   = 10 * TMS;
  localparam int T_LOCK  = 500 * CLK_MHZ;
  localparam int SLACK   = 12;

  logic clk = 0, rst_n = 0, start = 0;
  logic readback_en = 0, pclk_ref = 0;
  logic [7:0] hsync_len = 0, hbp_len = 0, hfp_len = 0, vsync_len = 0, vbp_len = 0, vfp_len = 0;
  logic [15:0] h_active = 0, v_active = 0, pll_word = 0, sleep_exit_ms = 0, disp_on_ms = 0;
  logic [1:0] pix_fmt = 0;
  logic [2:0] lane_cnt = 1;
  logic [5:0] lp_div = 0;
  logic bridge_rst_n, acc_valid, acc_write, busy, done, error;
  logic acc_ready = 0, acc_done = 0;
  logic [7:0] acc_addr;
  logic [15:0] acc_wdata, acc_rdata = 0;

  bridge_init_seq #(.CLK_MHZ(CLK_MHZ), .US_PER_MS(UPM)) dut (.*);

  always #10 clk = ~clk;

  typedef struct { bit wr; bit [7:0] addr; bit [15:0] data; int gap; string req; } item_t;
  item_t exp_q[$];

  int nchk = 0, nfail = 0, cyc = 0;
  int ref_t = 0, t_fall = 0, rst_pulses = 0;
  int rdy_dly = 0, done_dly = 0;
  bit [15:0] id_resp = 16'h2828, cfg_resp = 16'h0301;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic push(input bit wr, input bit [7:0] a, input bit [15:0] d, input int gap, input string req);
    item_t it;
    it.wr = wr; it.addr = a; it.data = d; it.gap = gap; it.req = req;
    exp_q.push_back(it);
  endtask

  // driver side: expected request list derived from the requirements
  task automatic expect_run(input bit rb, input bit id_bad, input bit cfg_bad);
    bit [15:0] cfgv;
    cfgv = 16'h0342 | (pclk_ref ? 16'h0020 : 16'h0000);
    if (rb) begin
      push(0, 8'hB0, 0, T_RST, "R3");
      if (id_bad) return;
      push(0, 8'hB7, 0, 0, "R3");
      if (cfg_bad) return;
      push(1, 8'hB1, {vsync_len, hsync_len}, 0, "R5");
    end else push(1, 8'hB1, {vsync_len, hsync_len}, T_RST, "R4");
    push(1, 8'hB2, {8'(vsync_len + vbp_len), 8'(hsync_len + hbp_len)}, 0, "R5");
    push(1, 8'hB3, {vfp_len, hfp_len}, 0, "R5");
    push(1, 8'hB4, h_active, 0, "R5");
    push(1, 8'hB5, v_active, 0, "R5");
    push(1, 8'hB6, 16'h0008 | pix_fmt, 0, "R5");
    push(1, 8'hDE, 16'(lane_cnt - 1), 0, "R5");
    push(1, 8'hB7, cfgv, 0, "R6");
    push(1, 8'hBA, pll_word, 0, "R7");
    push(1, 8'hB8, 16'h0000, 0, "R7");
    push(1, 8'hBB, {10'd0, lp_div}, 0, "R7");
    push(1, 8'hB9, 16'h0001, 0, "R7");
    push(1, 8'hBC, 16'h0001, T_LOCK, "R7");
    push(1, 8'hBF, 16'h0011, 0, "R8");
    push(1, 8'hBC, 16'h0001, sleep_exit_ms * TMS, "R8");
    push(1, 8'hBF, 16'h0029, 0, "R8");
    push(1, 8'hB7, cfgv | 16'h0009, disp_on_ms * TMS, "R9");
  endtask

  // monitor of the reset line
  bit prev_rst = 1;
  always @(negedge clk) begin
    if (prev_rst && !bridge_rst_n) begin t_fall = cyc; rst_pulses++; end
    if (!prev_rst && bridge_rst_n) begin
      chk((cyc - t_fall) >= T_RST && (cyc - t_fall) <= T_RST + 4, "R2 reset low width", cyc - t_fall, T_RST);
      ref_t = cyc;
    end
    prev_rst = bridge_rst_n;
  end

  // register-port responder and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (acc_valid) begin
        item_t it;
        int gap;
        repeat (rdy_dly) @(negedge clk);
        gap = cyc - ref_t;
        if (exp_q.size() == 0) begin
          chk(0, "R3 unexpected request", {acc_write, acc_addr}, 0);
        end else begin
          it = exp_q.pop_front();
          chk(acc_write == it.wr && acc_addr == it.addr, it.req, {acc_write, acc_addr}, {it.wr, it.addr});
          if (it.wr) chk(acc_wdata == it.data, it.req, acc_wdata, it.data);
          if (it.gap > 0) chk(gap >= it.gap && gap <= it.gap + SLACK + rdy_dly, {it.req, " gap"}, gap, it.gap);
        end
        acc_rdata = (acc_addr == 8'hB0) ? id_resp : cfg_resp;
        acc_ready = 1;
        @(negedge clk);
        acc_ready = 0;
        repeat (done_dly) @(negedge clk);
        acc_done = 1;
        ref_t = cyc;
        @(negedge clk);
        acc_done = 0;
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_end();
    int n = 0;
    while (!(done || error) && n < 20000) begin @(negedge clk); n++; end
    repeat (60) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int pulses0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(bridge_rst_n == 1 && acc_valid == 0, "R1 rst/valid", {bridge_rst_n, acc_valid}, 2'b10);
    chk(busy == 0 && done == 0 && error == 0, "R1 flags", {busy, done, error}, 0);

    // Run A: readback, zero-latency port, mid-run start pulse (R11)
    readback_en = 1; pclk_ref = 0;
    hsync_len = 4; hbp_len = 20; hfp_len = 8; vsync_len = 2; vbp_len = 10; vfp_len = 5;
    h_active = 800; v_active = 480; pix_fmt = 3; lane_cnt = 4; pll_word = 16'h4214;
    lp_div = 6; sleep_exit_ms = 3; disp_on_ms = 2;
    rdy_dly = 0; done_dly = 0;
    expect_run(1, 0, 0);
    pulses0 = rst_pulses;
    pulse_start();
    repeat (700) @(negedge clk);
    pulse_start();
    repeat (2) @(negedge clk);
    chk(busy == 1 && bridge_rst_n == 1, "R11 start while busy", {busy, bridge_rst_n}, 2'b11);
    wait_end();
    chk(done == 1 && error == 0 && busy == 0, "R9 done flags", {done, error, busy}, 3'b100);
    chk(exp_q.size() == 0, "R9 all requests seen", exp_q.size(), 0);
    chk(rst_pulses - pulses0 == 1, "R11 single reset pulse", rst_pulses - pulses0, 1);

    // Run B: no readback, pclk reference, back-pressure, byte wrap, zero sleep wait (R12 restart)
    readback_en = 0; pclk_ref = 1;
    hsync_len = 200; hbp_len = 100; vsync_len = 150; vbp_len = 150; hfp_len = 1; vfp_len = 2;
    h_active = 16'h1234; v_active = 16'h0ABC; pix_fmt = 0; lane_cnt = 1; pll_word = 16'hC1FF;
    lp_div = 63; sleep_exit_ms = 0; disp_on_ms = 1;
    rdy_dly = 3; done_dly = 2;
    expect_run(0, 0, 0);
    pulse_start();
    @(negedge clk);
    chk(done == 0 && busy == 1, "R12 restart clears done", {done, busy}, 2'b01);
    wait_end();
    chk(done == 1 && error == 0, "R9 done B", {done, error}, 2'b10);
    chk(exp_q.size() == 0, "R4 all requests seen", exp_q.size(), 0);

    // Run C: identity mismatch
    readback_en = 1; pclk_ref = 0; rdy_dly = 1; done_dly = 1;
    id_resp = 16'h1234;
    expect_run(1, 1, 0);
    pulse_start();
    wait_end();
    repeat (200) @(negedge clk);
    chk(error == 1 && done == 0 && busy == 0, "R3 id error", {error, done, busy}, 3'b100);
    chk(bridge_rst_n == 1 && acc_valid == 0, "R3 quiet after error", {bridge_rst_n, acc_valid}, 2'b10);
    chk(exp_q.size() == 0, "R3 reads seen", exp_q.size(), 0);

    // Run D: default-value mismatch
    id_resp = 16'h2828; cfg_resp = 16'h0300;
    expect_run(1, 0, 1);
    pulse_start();
    wait_end();
    repeat (200) @(negedge clk);
    chk(error == 1 && busy == 0, "R3 default error", {error, busy}, 2'b10);
    chk(exp_q.size() == 0, "R3 both reads seen", exp_q.size(), 0);

    // Run E: restart after error, full success
    cfg_resp = 16'h0301; rdy_dly = 0; done_dly = 0;
    sleep_exit_ms = 1; disp_on_ms = 0;
    expect_run(1, 0, 0);
    pulse_start();
    @(negedge clk);
    chk(error == 0, "R12 restart clears error", error, 0);
    wait_end();
    chk(done == 1 && error == 0, "R12 rerun done", {done, error}, 2'b10);
    chk(exp_q.size() == 0, "R12 all requests seen", exp_q.size(), 0);

    summary();
  end
endmodule